// File: doc/BRIEF.md
# Bus protection error monitor

This block watches the protection information on a parallel peripheral bus and turns every error it sees into a sticky status flag. Five error sources are covered: odd parity on the low data byte, failed CRC checks, odd parity on the upper byte lane, a phase change that arrives without a CRC request after data has moved, and parity errors reported by the host-side bus master. Any status flag whose interrupt enable is set drives a single level interrupt line. Software clears flags by writing ones to them.

The block also keeps a CRC-request-OK flag. The flag is set when a CRC request has been issued and no data has moved since that request. Target-side control logic reads this flag so that it does not send two CRC requests back to back. For every data byte it accepts, the block captures the byte and generates its odd parity bit, so the byte and its parity can be read back.

A configuration word holds the per-source interrupt enables, the enables for the master and upper-lane checks, and the disables for CRC and protocol checking. Its reset value turns every check and every interrupt on.

Top module: `bus_prot_monitor`

## Requirements
- R1: When `dat_valid` is high and `dat_byte` with `dat_par` holds an even number of ones, status bit 0 (parity) is set at the next clock edge.
- R2: When `dat_valid` is high, the next edge loads `lat_byte_o` with `dat_byte` and loads `lat_par_o` with the bit that makes the nine bits odd. Otherwise both outputs hold their values.
- R3: When `crc_chk_stb` and `crc_chk_bad` are both high, status bit 1 (CRC) is set. This does not happen while configuration bit 7 (CRC check disable) is set.
- R4: Status bit 2 (upper lane) is set when `lane_valid` is high, `lane_byte` with `lane_par` holds an even number of ones, configuration bit 6 is set, and `phase_i` is command (2), status (3), message out (6) or message in (7). In any other phase, or while bit 6 is clear, the bit is not set.
- R5: `crc_req_ok_o` rises one edge after `crc_req_stb` and falls one edge after `xfer_stb`. When both strobes arrive in the same cycle, the transfer wins.
- R6: Status bit 3 (protocol) is set when `phase_chg_stb` arrives while data has moved since the last CRC request or last phase change, counting a transfer in the same cycle. Configuration bit 8 (protocol check disable) suppresses it.
- R7: When `mst_perr_stb` is high, status bit 4 (master) is set. This happens only while configuration bit 5 is set.
- R8: Status bits are sticky. When `clr_we` is high, the bits set in `clr_mask` are cleared. A set that arrives in the same cycle as its clear wins.
- R9: `irq_o` equals the OR of status bits ANDed with configuration bits 4:0, delayed by one clock. A status bit whose enable is clear still sets, but it does not raise `irq_o`.
- R10: Reset (synchronous, active low) clears status, `irq_o`, `crc_req_ok_o` and the latched byte and parity, and loads the configuration with 0x07F. `cfg_we` writes `cfg_wdata` into the configuration at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 9 | Configuration write data |
| cfg_o | output | 9 | Current configuration |
| clr_we | input | 1 | Status clear strobe |
| clr_mask | input | 5 | Write-one-to-clear mask for status |
| phase_i | input | 3 | Current bus phase code |
| dat_valid | input | 1 | Low data byte valid |
| dat_byte | input | 8 | Low data byte |
| dat_par | input | 1 | Odd parity bit of the low byte |
| lane_valid | input | 1 | Upper lane byte valid |
| lane_byte | input | 8 | Upper lane byte |
| lane_par | input | 1 | Odd parity bit of the upper lane |
| crc_chk_stb | input | 1 | CRC check result strobe |
| crc_chk_bad | input | 1 | CRC check failed |
| crc_req_stb | input | 1 | CRC request issued |
| xfer_stb | input | 1 | Data transferred |
| phase_chg_stb | input | 1 | Bus phase change |
| mst_perr_stb | input | 1 | Host master data parity error |
| status_o | output | 5 | Sticky error flags |
| crc_req_ok_o | output | 1 | A CRC request may be issued |
| lat_byte_o | output | 8 | Latched low data byte |
| lat_par_o | output | 1 | Generated odd parity of latched byte |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench builds the block with its defaults: an 8-bit data byte, a 3-bit phase code and the command, status and message phases at codes 2, 3, 6 and 7. An 8-bit byte lets the random stimulus reach both parity outcomes about equally often. The 3-bit phase code puts every phase, both gated and ungated, within reach of the upper-lane check. The configuration is rewritten many times during the run, so each disable bit and each interrupt mask is exercised while errors keep arriving, including clears that land in the same cycle as a new error.

// File: rtl/bpm_pkg.sv
// Shared definitions for the bus protection monitor.
// Assumes five error sources in a fixed bit order that software decodes.
package bpm_pkg;
    localparam int NUM_ERR   = 5;
    localparam int ERR_PAR   = 0;
    localparam int ERR_CRC   = 1;
    localparam int ERR_LANE  = 2;
    localparam int ERR_PROTO = 3;
    localparam int ERR_MST   = 4;

    typedef struct packed {
        logic               proto_dis;
        logic               crc_dis;
        logic               lane_en;
        logic               mst_en;
        logic [NUM_ERR-1:0] ie;
    } cfg_t;

    localparam int   CFG_W   = $bits(cfg_t);
    localparam cfg_t CFG_RST = '{proto_dis: 1'b0, crc_dis: 1'b0, lane_en: 1'b1,
                                 mst_en: 1'b1, ie: {NUM_ERR{1'b1}}};
endpackage

// File: rtl/bpm_cfg_reg.sv
// Configuration register: holds enables and disables, loaded by a write strobe.
// Assumes the reset value turns every check and interrupt on.
module bpm_cfg_reg
    import bpm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [CFG_W-1:0] wdata_i,
    output cfg_t             cfg_q
);
    // Load the configuration on a write, restore defaults on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    cfg_q <= CFG_RST;
        else if (we_i) cfg_q <= cfg_t'(wdata_i);
    end

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(cfg_q)); // R10
endmodule

// File: rtl/bpm_crc_track.sv
// Tracks the CRC request protocol: whether a request is allowed and whether
// data has moved since the last request or phase change.
// Assumes the strobes are single-cycle; a transfer wins over a request.
module bpm_crc_track (
    input  logic clk,
    input  logic rst_n,
    input  logic crc_req_i,
    input  logic xfer_i,
    input  logic phase_chg_i,
    output logic ok_q,
    output logic proto_hit_o
);
    logic dirty_q;

    // A phase change is a violation if data moved since the last request.
    always_comb proto_hit_o = phase_chg_i & (dirty_q | xfer_i);

    // Update the request-OK and data-moved flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ok_q    <= 1'b0;
            dirty_q <= 1'b0;
        end else if (xfer_i) begin
            ok_q    <= 1'b0;
            dirty_q <= 1'b1;
        end else if (crc_req_i) begin
            ok_q    <= 1'b1;
            dirty_q <= 1'b0;
        end else if (phase_chg_i) begin
            dirty_q <= 1'b0;
        end
    end

    AST_OK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_i |=> !ok_q); // R5
    AST_OK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_req_i && !xfer_i) |=> ok_q); // R5
endmodule

// File: rtl/bpm_detect.sv
// Error detection: turns bus strobes and data into per-source error pulses.
// Assumes odd parity on both byte lanes; the upper lane is checked only in
// the command, status and message phases.
module bpm_detect
    import bpm_pkg::*;
#(
    parameter int                 DATA_W  = 8,
    parameter int                 PHASE_W = 3,
    parameter logic [PHASE_W-1:0] PH_CMD  = 3'd2,
    parameter logic [PHASE_W-1:0] PH_STAT = 3'd3,
    parameter logic [PHASE_W-1:0] PH_MOUT = 3'd6,
    parameter logic [PHASE_W-1:0] PH_MIN  = 3'd7
) (
    input  cfg_t               cfg_i,
    input  logic [PHASE_W-1:0] phase_i,
    input  logic               dat_valid_i,
    input  logic [DATA_W-1:0]  dat_byte_i,
    input  logic               dat_par_i,
    input  logic               lane_valid_i,
    input  logic [DATA_W-1:0]  lane_byte_i,
    input  logic               lane_par_i,
    input  logic               crc_stb_i,
    input  logic               crc_bad_i,
    input  logic               proto_hit_i,
    input  logic               mst_perr_i,
    output logic [NUM_ERR-1:0] set_o
);
    localparam int N_PH = 4;
    localparam logic [PHASE_W-1:0] LANE_PH [N_PH] = '{PH_CMD, PH_STAT, PH_MOUT, PH_MIN};

    logic [N_PH-1:0] ph_hit;
    logic            lane_phase;

    for (genvar i = 0; i < N_PH; i++) begin : g_ph
        assign ph_hit[i] = (phase_i == LANE_PH[i]);
    end

    // Decide whether the current phase carries upper-lane protection.
    always_comb lane_phase = |ph_hit;

    // Build the per-source error pulses from the gating rules.
    always_comb begin
        set_o            = '0;
        set_o[ERR_PAR]   = dat_valid_i & ~(^{dat_byte_i, dat_par_i});
        set_o[ERR_CRC]   = crc_stb_i & crc_bad_i & ~cfg_i.crc_dis;
        set_o[ERR_LANE]  = lane_valid_i & cfg_i.lane_en & lane_phase
                           & ~(^{lane_byte_i, lane_par_i});
        set_o[ERR_PROTO] = proto_hit_i & ~cfg_i.proto_dis;
        set_o[ERR_MST]   = mst_perr_i & cfg_i.mst_en;
    end
endmodule

// File: rtl/bpm_status.sv
// Sticky status flags with write-one-to-clear and a registered interrupt.
// Assumes a set in the same cycle as its clear must win.
module bpm_status
    import bpm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_ERR-1:0] set_i,
    input  logic               clr_we_i,
    input  logic [NUM_ERR-1:0] clr_mask_i,
    input  logic [NUM_ERR-1:0] ie_i,
    output logic [NUM_ERR-1:0] status_q,
    output logic               irq_q
);
    logic [NUM_ERR-1:0] clr_eff;

    // Apply the clear mask only while the clear strobe is high.
    always_comb clr_eff = clr_we_i ? clr_mask_i : '0;

    // Hold sticky flags; new errors override a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_eff) | set_i;
    end

    // Register the OR of enabled flags as a level interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(status_q & ie_i);
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((status_q & $past(set_i)) == $past(set_i))); // R8
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we_i |=> ((status_q & $past(status_q)) == $past(status_q))); // R8
endmodule

// File: rtl/bus_prot_monitor.sv
// Bus protection error monitor top: parity, CRC, upper-lane and protocol
// checks feeding sticky flags and one level interrupt.
// Assumes all strobes are synchronous to clk and one cycle wide.
module bus_prot_monitor
    import bpm_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int PHASE_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [CFG_W-1:0]   cfg_wdata,
    output logic [CFG_W-1:0]   cfg_o,
    input  logic               clr_we,
    input  logic [NUM_ERR-1:0] clr_mask,
    input  logic [PHASE_W-1:0] phase_i,
    input  logic               dat_valid,
    input  logic [DATA_W-1:0]  dat_byte,
    input  logic               dat_par,
    input  logic               lane_valid,
    input  logic [DATA_W-1:0]  lane_byte,
    input  logic               lane_par,
    input  logic               crc_chk_stb,
    input  logic               crc_chk_bad,
    input  logic               crc_req_stb,
    input  logic               xfer_stb,
    input  logic               phase_chg_stb,
    input  logic               mst_perr_stb,
    output logic [NUM_ERR-1:0] status_o,
    output logic               crc_req_ok_o,
    output logic [DATA_W-1:0]  lat_byte_o,
    output logic               lat_par_o,
    output logic               irq_o
);
    cfg_t               cfg_q;
    logic               proto_hit;
    logic [NUM_ERR-1:0] err_set;

    bpm_cfg_reg u_cfg (
        .clk(clk), .rst_n(rst_n), .we_i(cfg_we), .wdata_i(cfg_wdata), .cfg_q(cfg_q)
    );

    bpm_crc_track u_crc (
        .clk(clk), .rst_n(rst_n), .crc_req_i(crc_req_stb), .xfer_i(xfer_stb),
        .phase_chg_i(phase_chg_stb), .ok_q(crc_req_ok_o), .proto_hit_o(proto_hit)
    );

    bpm_detect #(.DATA_W(DATA_W), .PHASE_W(PHASE_W)) u_det (
        .cfg_i(cfg_q), .phase_i(phase_i),
        .dat_valid_i(dat_valid), .dat_byte_i(dat_byte), .dat_par_i(dat_par),
        .lane_valid_i(lane_valid), .lane_byte_i(lane_byte), .lane_par_i(lane_par),
        .crc_stb_i(crc_chk_stb), .crc_bad_i(crc_chk_bad), .proto_hit_i(proto_hit),
        .mst_perr_i(mst_perr_stb), .set_o(err_set)
    );

    bpm_status u_st (
        .clk(clk), .rst_n(rst_n), .set_i(err_set), .clr_we_i(clr_we),
        .clr_mask_i(clr_mask), .ie_i(cfg_q.ie), .status_q(status_o), .irq_q(irq_o)
    );

    // Expose the configuration for read-back.
    always_comb cfg_o = cfg_q;

    // Capture the accepted byte and generate its odd parity bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_byte_o <= '0;
            lat_par_o  <= 1'b0;
        end else if (dat_valid) begin
            lat_byte_o <= dat_byte;
            lat_par_o  <= ~(^dat_byte);
        end
    end

    AST_LAT_ODD: assert property (@(posedge clk) disable iff (!rst_n)
        dat_valid |=> (^{lat_byte_o, lat_par_o})); // R2
    AST_PAR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_valid && !(^{dat_byte, dat_par})) |=> status_o[ERR_PAR]); // R1
    AST_CRC_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.crc_dis && !status_o[ERR_CRC]) |=> !status_o[ERR_CRC]); // R3
    AST_LANE_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_q.lane_en && !status_o[ERR_LANE]) |=> !status_o[ERR_LANE]); // R4
    AST_PROTO_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.proto_dis && !status_o[ERR_PROTO]) |=> !status_o[ERR_PROTO]); // R6
    AST_MST_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_q.mst_en && !status_o[ERR_MST]) |=> !status_o[ERR_MST]); // R7
    AST_IRQ_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (|(status_o & cfg_q.ie)) |=> irq_o); // R9
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_o & cfg_q.ie) == '0) |=> !irq_o); // R9
endmodule

// File: tb/bus_prot_monitor_tb_top.sv
// Bench: behavioural reference model updated at each rising edge and
// compared against every output at each falling edge.
module bus_prot_monitor_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 0;
    logic [8:0] cfg_wdata = 0;
    logic [8:0] cfg_o;
    logic       clr_we = 0;
    logic [4:0] clr_mask = 0;
    logic [2:0] phase_i = 0;
    logic       dat_valid = 0;
    logic [7:0] dat_byte = 0;
    logic       dat_par = 0;
    logic       lane_valid = 0;
    logic [7:0] lane_byte = 0;
    logic       lane_par = 0;
    logic       crc_chk_stb = 0, crc_chk_bad = 0, crc_req_stb = 0, xfer_stb = 0;
    logic       phase_chg_stb = 0, mst_perr_stb = 0;
    logic [4:0] status_o;
    logic       crc_req_ok_o, lat_par_o, irq_o;
    logic [7:0] lat_byte_o;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    // reference model state
    int m_st, m_cfg, m_ok, m_dirty, m_irq, m_lb, m_lp;

    always #5 clk = ~clk;

    bus_prot_monitor dut_i (.*);

    // Reference model: next state from the inputs seen at this edge.
    always @(posedge clk) begin
        int set, ie, ones;
        if (!rst_n) begin
            m_st = 0; m_cfg = 'h07F; m_ok = 0; m_dirty = 0; m_irq = 0; m_lb = 0; m_lp = 0;
        end else begin
            set = 0;
            ie = m_cfg & 'h1F;
            ones = $countones({dat_byte, dat_par});
            if (dat_valid && (ones % 2 == 0)) set |= 1;
            if (crc_chk_stb && crc_chk_bad && !m_cfg[7]) set |= 2;
            ones = $countones({lane_byte, lane_par});
            if (lane_valid && m_cfg[6] && (ones % 2 == 0) &&
                (phase_i == 2 || phase_i == 3 || phase_i == 6 || phase_i == 7)) set |= 4;
            if (phase_chg_stb && !m_cfg[8] && (m_dirty || xfer_stb)) set |= 8;
            if (mst_perr_stb && m_cfg[5]) set |= 16;
            m_irq = ((m_st & ie) != 0);
            m_st = (m_st & ~(clr_we ? int'(clr_mask) : 0)) | set;
            if (xfer_stb) begin m_ok = 0; m_dirty = 1; end
            else if (crc_req_stb) begin m_ok = 1; m_dirty = 0; end
            else if (phase_chg_stb) m_dirty = 0;
            if (dat_valid) begin
                m_lb = dat_byte;
                m_lp = ($countones(dat_byte) % 2 == 0);
            end
            if (cfg_we) m_cfg = cfg_wdata;
        end
    end

    task automatic chk(string req, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare every output against the model.
    task automatic compare_all();
        chk("R1 parity flag", status_o[0], m_st & 1);
        chk("R3 crc flag", status_o[1], (m_st >> 1) & 1);
        chk("R4 lane flag", status_o[2], (m_st >> 2) & 1);
        chk("R6 protocol flag", status_o[3], (m_st >> 3) & 1);
        chk("R7 master flag", status_o[4], (m_st >> 4) & 1);
        chk("R5 crc_req_ok", crc_req_ok_o, m_ok);
        chk("R2 latched byte", lat_byte_o, m_lb);
        chk("R2 latched parity", lat_par_o, m_lp);
        chk("R9 irq", irq_o, m_irq);
        chk("R10 cfg", cfg_o, m_cfg);
    endtask

    task automatic idle();
        cfg_we = 0; clr_we = 0; clr_mask = 0; dat_valid = 0; lane_valid = 0;
        crc_chk_stb = 0; crc_chk_bad = 0; crc_req_stb = 0; xfer_stb = 0;
        phase_chg_stb = 0; mst_perr_stb = 0;
    endtask

    // One cycle: inputs already set, wait edge, compare at the falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        compare_all();
        idle();
    endtask

    task automatic clear_all();
        clr_we = 1; clr_mask = 5'h1F; step();
    endtask

    initial begin
        idle();
        repeat (3) @(negedge clk);
        @(posedge clk); @(negedge clk);
        // R10: reset state
        chk("R10 reset status", status_o, 0);
        chk("R10 reset cfg", cfg_o, 'h07F);
        chk("R10 reset irq", irq_o, 0);
        compare_all();
        rst_n = 1;
        step();

        // R1: bad parity, then good parity
        dat_valid = 1; dat_byte = 8'hA5; dat_par = 0; step();
        step();
        chk("R9 irq after parity", irq_o, 1);
        clear_all(); step();
        dat_valid = 1; dat_byte = 8'h01; dat_par = 0; step();
        chk("R1 good parity no flag", status_o[0], 0);

        // R8: clear and set in the same cycle, set wins
        dat_valid = 1; dat_byte = 8'h00; dat_par = 0; clr_we = 1; clr_mask = 5'h01; step();
        chk("R8 set wins", status_o[0], 1);
        clear_all();

        // R3: crc error gated by disable
        cfg_we = 1; cfg_wdata = 9'h0FF; step();
        crc_chk_stb = 1; crc_chk_bad = 1; step();
        chk("R3 crc disabled", status_o[1], 0);
        cfg_we = 1; cfg_wdata = 9'h07F; step();
        crc_chk_stb = 1; crc_chk_bad = 1; step();
        chk("R3 crc enabled", status_o[1], 1);
        clear_all();

        // R4: lane checked in phase 2 only, not in phase 0
        phase_i = 0; lane_valid = 1; lane_byte = 8'h03; lane_par = 0; step();
        chk("R4 data phase ignored", status_o[2], 0);
        phase_i = 2; lane_valid = 1; lane_byte = 8'h03; lane_par = 0; step();
        chk("R4 command phase", status_o[2], 1);
        clear_all();

        // R5/R6: request, transfer, phase change
        crc_req_stb = 1; step();
        chk("R5 ok set", crc_req_ok_o, 1);
        xfer_stb = 1; step();
        chk("R5 ok clear", crc_req_ok_o, 0);
        phase_chg_stb = 1; step();
        chk("R6 protocol error", status_o[3], 1);
        clear_all();
        xfer_stb = 1; step();
        crc_req_stb = 1; step();
        phase_chg_stb = 1; step();
        chk("R6 legal phase change", status_o[3], 0);

        // R7/R9: masked master error sets status but no irq
        cfg_we = 1; cfg_wdata = 9'h06F; step();
        mst_perr_stb = 1; step();
        step();
        chk("R7 master flag", status_o[4], 1);
        chk("R9 masked irq", irq_o, 0);
        clear_all();

        // random phase: every output compared every cycle
        for (int i = 0; i < 4000; i++) begin
            phase_i       = 3'($urandom);
            dat_valid     = ($urandom % 3) == 0;
            dat_byte      = 8'($urandom);
            dat_par       = 1'($urandom);
            lane_valid    = ($urandom % 3) == 0;
            lane_byte     = 8'($urandom);
            lane_par      = 1'($urandom);
            crc_chk_stb   = ($urandom % 6) == 0;
            crc_chk_bad   = 1'($urandom);
            crc_req_stb   = ($urandom % 5) == 0;
            xfer_stb      = ($urandom % 4) == 0;
            phase_chg_stb = ($urandom % 7) == 0;
            mst_perr_stb  = ($urandom % 9) == 0;
            clr_we        = ($urandom % 4) == 0; // R8 clears collide with sets
            clr_mask      = 5'($urandom);
            cfg_we        = ($urandom % 50) == 0;
            cfg_wdata     = 9'($urandom);
            step();
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule